// File: doc/BRIEF.md
# Probabilistic Row Scrub Trigger

When one line of a memory row is read, other lines in the same row can be disturbed. Their contents can change without anyone noticing, and the damage stays hidden until those lines are read. The stored code corrects two bad bits per line and detects three. A line must therefore be repaired before a third fault lands in it.

This block watches the stream of line reads to the memory. On each observed read it decides at random, with a small programmable probability, whether to clean the whole row that the read touched. The random source is a 16-bit LFSR inside the block. A read whose draw is below the threshold starts a scrub of that row.

During a scrub the block reads every line of the row in turn through the external corrector. It writes a line back only when the corrector reports that it fixed the line. A line the corrector cannot repair is left alone, and a sticky error flag records its row and line. Reads that are not selected cause no action at all.

Top module: `row_scrub_trigger`

## Requirements
- R1: The random source is a 16-bit LFSR that resets to 0xACE1. On each step it shifts left by one bit and puts bit15^bit13^bit12^bit10 into bit 0. It steps once for every cycle with `obs_valid` high, whether or not a scrub is running and whatever the decision. It is never zero.
- R2: A scrub starts when `obs_valid` is high, no scrub is running, and the LFSR value before that read's step is below the threshold (unsigned compare). `busy` is high from the cycle after that read, and the scrubbed row is `obs_row` of that read.
- R3: The threshold resets to parameter THR_INIT, which defaults to 655 (about 1%). A cycle with `thr_we` high loads `thr_wdata`, and the new value applies from the next cycle. With a threshold of 0, reads never start a scrub: no command is issued and `busy` stays low.
- R4: A scrub issues one read command (`cmd_valid`=1, `cmd_write`=0) for each line index 0 to LINES-1, in ascending order, all carrying the scrubbed row. Each read after the first waits for the status of the one before it, so two read commands are never on consecutive cycles.
- R5: A write command (`cmd_valid`=1, `cmd_write`=1) for the same row and line is issued in the cycle right after a status with `sts_corrected`=1 and `sts_uncorrectable`=0, and at no other time.
- R6: A status with `sts_uncorrectable`=1 causes no write-back, even if `sts_corrected` is also high. It sets `err_flag`, and `err_row`/`err_line` latch that row and line. Later uncorrectable lines do not change these values. Only reset clears them.
- R7: Reads observed during a scrub start no new scrub and do not change the row being scrubbed.
- R8: After the last line's status (and its write-back, if any) the scrub ends. `busy` goes low and no further commands appear until a new trigger.
- R9: In reset, `busy`, `cmd_valid` and `err_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obs_valid | input | 1 | A line read to the memory is observed this cycle |
| obs_row | input | ROW_W | Row of the observed read |
| thr_we | input | 1 | Load the trigger threshold |
| thr_wdata | input | 16 | New threshold value |
| sts_valid | input | 1 | Corrector status for the pending scrub read |
| sts_corrected | input | 1 | The line held correctable errors and was fixed |
| sts_uncorrectable | input | 1 | The line holds errors beyond repair |
| busy | output | 1 | A row scrub is in progress |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_write | output | 1 | 1 = write-back of the corrected line, 0 = scrub read |
| cmd_row | output | ROW_W | Row of the command |
| cmd_line | output | LINE_W | Line index of the command |
| err_flag | output | 1 | Sticky: an uncorrectable line was found |
| err_row | output | ROW_W | Row of the first uncorrectable line |
| err_line | output | LINE_W | Line of the first uncorrectable line |

## Verification
The embedded assertions check the following on every cycle:
- the LFSR never locks at zero;
- a qualifying read always raises `busy`;
- no two read commands are back to back;
- a write-back follows only a clean corrected status;
- the scrubbed row holds steady for the whole scrub;
- the error record, once set, never moves.

Only the bench's scenarios can show the rest. The bench runs its own LFSR model to predict which reads trigger. It then compares the full logged command sequence against the corrected and uncorrectable pattern of each row. It also shows that reads during a scrub are ignored yet still step the random source, that a zero threshold stays silent, and that the first uncorrectable line is the one retained.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_READ,
        SC_WAIT,
        SC_WBACK
    } scrub_state_e;

    typedef struct packed {
        logic valid;
        logic corrected;
        logic uncorrectable;
    } ecc_status_t;

    // maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] v);
        return {v[RND_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

endpackage

// File: rtl/scrub_lfsr.sv
module scrub_lfsr
    import scrub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [RND_W-1:0] value
);

    logic [RND_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RND_SEED;
        end else if (step) begin
            state_q <= rnd_step(state_q);
        end
    end

    assign value = state_q;

    // R1: a maximal-length sequence never reaches the all-zero lock state
    assert_rnd_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
    import scrub_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int LINES  = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  start_row,
    input  ecc_status_t       status,
    output logic              busy,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [LINE_W-1:0] cmd_line,
    output logic              unc_hit
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    scrub_state_e      state_q, state_d;
    logic [ROW_W-1:0]  row_q;
    logic [LINE_W-1:0] line_q, line_d;
    logic              is_last;
    logic              need_wb;

    assign is_last = (line_q == LAST_LINE);
    assign need_wb = status.corrected && !status.uncorrectable;

    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        unique case (state_q)
            SC_IDLE: begin
                if (start) begin
                    state_d = SC_READ;
                    line_d  = '0;
                end
            end
            SC_READ: state_d = SC_WAIT;
            SC_WAIT: begin
                if (status.valid) begin
                    if (need_wb) begin
                        state_d = SC_WBACK;
                    end else if (is_last) begin
                        state_d = SC_IDLE;
                    end else begin
                        state_d = SC_READ;
                        line_d  = line_q + 1'b1;
                    end
                end
            end
            SC_WBACK: begin
                if (is_last) begin
                    state_d = SC_IDLE;
                end else begin
                    state_d = SC_READ;
                    line_d  = line_q + 1'b1;
                end
            end
            default: state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_IDLE;
            line_q  <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            if (state_q == SC_IDLE && start) begin
                row_q <= start_row;
            end
        end
    end

    assign busy      = (state_q != SC_IDLE);
    assign cmd_valid = (state_q == SC_READ) || (state_q == SC_WBACK);
    assign cmd_write = (state_q == SC_WBACK);
    assign cmd_row   = row_q;
    assign cmd_line  = line_q;
    assign unc_hit   = (state_q == SC_WAIT) && status.valid && status.uncorrectable;

    // R4: a read is always followed by a wait for its status
    assert_no_back_to_back_read_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write) |=> !(cmd_valid && !cmd_write));

    // R5: a write-back only right after a clean corrected status
    assert_wb_after_corrected_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write) |->
            $past(status.valid && status.corrected && !status.uncorrectable));

    // R6: an uncorrectable line is never written back
    assert_no_wb_on_unc_R6: assert property (@(posedge clk) disable iff (rst)
        unc_hit |=> !cmd_write);

    // R7: the scrubbed row is frozen for the whole scrub
    assert_row_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_row));

endmodule

// File: rtl/scrub_err_latch.sv
module scrub_err_latch #(
    parameter int ROW_W  = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ROW_W-1:0]  hit_row,
    input  logic [LINE_W-1:0] hit_line,
    output logic              flag,
    output logic [ROW_W-1:0]  row,
    output logic [LINE_W-1:0] line
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            row  <= '0;
            line <= '0;
        end else if (hit && !flag) begin
            flag <= 1'b1;
            row  <= hit_row;
            line <= hit_line;
        end
    end

    // R6: once recorded, the error and its location never change until reset
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        $past(flag) |-> (flag && $stable(row) && $stable(line)));

endmodule

// File: rtl/row_scrub_trigger.sv
module row_scrub_trigger
    import scrub_pkg::*;
#(
    parameter int          ROW_W    = 8,
    parameter int          LINES    = 8,
    parameter logic [15:0] THR_INIT = 16'd655,
    localparam int         LINE_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              obs_valid,
    input  logic [ROW_W-1:0]  obs_row,
    input  logic              thr_we,
    input  logic [15:0]       thr_wdata,
    input  logic              sts_valid,
    input  logic              sts_corrected,
    input  logic              sts_uncorrectable,
    output logic              busy,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [LINE_W-1:0] cmd_line,
    output logic              err_flag,
    output logic [ROW_W-1:0]  err_row,
    output logic [LINE_W-1:0] err_line
);

    logic [RND_W-1:0] rnd;
    logic [15:0]      thr_q;
    logic             fire;
    logic             unc_hit;
    ecc_status_t      status;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= THR_INIT;
        end else if (thr_we) begin
            thr_q <= thr_wdata;
        end
    end

    assign status = '{valid: sts_valid, corrected: sts_corrected,
                      uncorrectable: sts_uncorrectable};

    scrub_lfsr i_rnd (
        .clk   (clk),
        .rst   (rst),
        .step  (obs_valid),
        .value (rnd)
    );

    assign fire = obs_valid && !busy && (rnd < thr_q);

    scrub_seq #(
        .ROW_W  (ROW_W),
        .LINES  (LINES),
        .LINE_W (LINE_W)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (fire),
        .start_row (obs_row),
        .status    (status),
        .busy      (busy),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_row   (cmd_row),
        .cmd_line  (cmd_line),
        .unc_hit   (unc_hit)
    );

    scrub_err_latch #(
        .ROW_W  (ROW_W),
        .LINE_W (LINE_W)
    ) i_err (
        .clk      (clk),
        .rst      (rst),
        .hit      (unc_hit),
        .hit_row  (cmd_row),
        .hit_line (cmd_line),
        .flag     (err_flag),
        .row      (err_row),
        .line     (err_line)
    );

    // R2: a qualifying read while idle always starts a scrub
    assert_trigger_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (obs_valid && !busy && (rnd < thr_q)) |=> busy);

    // R3: a zero threshold never lets an idle read start a scrub
    assert_zero_thr_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && (thr_q == 16'd0)) |=> !busy);

endmodule

// File: tb/test_row_scrub_trigger.sv
module test_row_scrub_trigger;

    localparam int ROW_W  = 8;
    localparam int LINES  = 8;
    localparam int LINE_W = 3;
    localparam int NVEC   = 12;

    // vector: {threshold, row, corrected mask, uncorrectable mask}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'hFFFF, 8'h12, 8'h00, 8'h00},
        {16'hFFFF, 8'h34, 8'h81, 8'h00},
        {16'h0000, 8'h56, 8'hFF, 8'h00},
        {16'h8000, 8'h21, 8'h0F, 8'h00},
        {16'h8000, 8'h22, 8'hF0, 8'h00},
        {16'hFFFF, 8'h7A, 8'h24, 8'h08},
        {16'hFFFF, 8'h7B, 8'hFF, 8'h40},
        {16'h8000, 8'h01, 8'h55, 8'h00},
        {16'h4000, 8'h02, 8'hAA, 8'h00},
        {16'hC000, 8'h03, 8'h11, 8'h00},
        {16'hFFFF, 8'hFF, 8'h80, 8'h00},
        {16'h0001, 8'h99, 8'h01, 8'h00}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              obs_valid = 1'b0;
    logic [ROW_W-1:0]  obs_row = '0;
    logic              thr_we = 1'b0;
    logic [15:0]       thr_wdata = '0;
    logic              sts_valid = 1'b0;
    logic              sts_corrected = 1'b0;
    logic              sts_uncorrectable = 1'b0;
    logic              busy, cmd_valid, cmd_write, err_flag;
    logic [ROW_W-1:0]  cmd_row, err_row;
    logic [LINE_W-1:0] cmd_line, err_line;

    row_scrub_trigger #(.ROW_W(ROW_W), .LINES(LINES)) i_row_scrub_trigger (
        .clk(clk), .rst(rst), .obs_valid(obs_valid), .obs_row(obs_row),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .sts_valid(sts_valid),
        .sts_corrected(sts_corrected), .sts_uncorrectable(sts_uncorrectable),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_row(cmd_row), .cmd_line(cmd_line), .err_flag(err_flag),
        .err_row(err_row), .err_line(err_line)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [15:0]       m_rnd = 16'hACE1;
    logic [15:0]       m_thr = 16'd655;
    logic [7:0]        cur_corr = '0;
    logic [7:0]        cur_unc = '0;
    logic              m_err = 1'b0;
    logic [ROW_W-1:0]  m_err_row = '0;
    logic [LINE_W-1:0] m_err_line = '0;

    logic              log_w [64];
    logic [ROW_W-1:0]  log_row [64];
    logic [LINE_W-1:0] log_line [64];
    int                log_n = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory and corrector model: logs commands, answers each read one cycle later
    initial begin
        logic pend = 1'b0;
        logic [LINE_W-1:0] pl = '0;
        forever begin
            @(negedge clk);
            sts_valid = 1'b0;
            sts_corrected = 1'b0;
            sts_uncorrectable = 1'b0;
            if (pend) begin
                sts_valid = 1'b1;
                sts_corrected = cur_corr[pl];
                sts_uncorrectable = cur_unc[pl];
                pend = 1'b0;
            end
            if (!rst && cmd_valid) begin
                if (log_n < 64) begin
                    log_w[log_n] = cmd_write;
                    log_row[log_n] = cmd_row;
                    log_line[log_n] = cmd_line;
                end
                log_n++;
                if (!cmd_write) begin
                    pend = 1'b1;
                    pl = cmd_line;
                end
            end
        end
    end

    task automatic set_thr(input logic [15:0] v);
        @(negedge clk);
        thr_we = 1'b1;
        thr_wdata = v;
        @(negedge clk);
        thr_we = 1'b0;
        m_thr = v;
    endtask

    // one observed read; returns whether the model predicts a new scrub
    task automatic do_read(input logic [ROW_W-1:0] row, input logic idle, output logic trig);
        @(negedge clk);
        obs_valid = 1'b1;
        obs_row = row;
        trig = idle && (m_rnd < m_thr);
        m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
        @(negedge clk);
        obs_valid = 1'b0;
        if (idle) check("R2 busy after read", 32'(busy), 32'(trig));
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 500) begin
            @(negedge clk);
            n++;
        end
        check("R8 scrub ends", 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        check("R8 no commands after end", 32'(cmd_valid), 32'd0);
    endtask

    task automatic check_log(input logic trig, input logic [ROW_W-1:0] row);
        int k = 0;
        logic ok = 1'b1;
        if (trig) begin
            for (int i = 0; i < LINES; i++) begin
                if (k >= log_n || log_w[k] !== 1'b0 || log_row[k] !== row || log_line[k] !== LINE_W'(i))
                    ok = 1'b0;
                k++;
                if (cur_corr[i] && !cur_unc[i]) begin
                    if (k >= log_n || log_w[k] !== 1'b1 || log_row[k] !== row || log_line[k] !== LINE_W'(i))
                        ok = 1'b0;
                    k++;
                end else if (cur_unc[i] && !m_err) begin
                    m_err = 1'b1;
                    m_err_row = row;
                    m_err_line = LINE_W'(i);
                end
            end
        end
        check("R4 R5 command count", 32'(log_n), 32'(k));
        check("R4 R5 R6 command sequence", 32'(ok), 32'd1);
        log_n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic t, t2;
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 busy in reset", 32'(busy), 32'd0);
        check("R9 cmd_valid in reset", 32'(cmd_valid), 32'd0);
        check("R9 err_flag in reset", 32'(err_flag), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        log_n = 0;

        // R3 reset threshold: draw 0xACE1 is above 655
        do_read(8'h10, 1'b1, t);
        wait_idle();
        check_log(t, 8'h10);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            set_thr(VEC[v][39:24]);
            cur_corr = VEC[v][15:8];
            cur_unc = VEC[v][7:0];
            log_n = 0;
            do_read(VEC[v][23:16], 1'b1, t);
            wait_idle();
            check_log(t, VEC[v][23:16]);
        end

        // R6 first uncorrectable location retained
        check("R6 err_flag", 32'(err_flag), 32'(m_err));
        check("R6 err_row", 32'(err_row), 32'(m_err_row));
        check("R6 err_line", 32'(err_line), 32'(m_err_line));

        // R7 reads during a scrub are ignored but step the LFSR (R1)
        set_thr(16'hFFFF);
        cur_corr = 8'h42;
        cur_unc = 8'h00;
        log_n = 0;
        do_read(8'h40, 1'b1, t);
        if (t) begin
            for (int i = 0; i < 3; i++) do_read(8'h41, 1'b0, t2);
            check("R7 still busy with first row", 32'(cmd_row), 32'h40);
        end
        wait_idle();
        check_log(t, 8'h40);

        // R3 zero threshold: no scrub at all
        set_thr(16'h0000);
        log_n = 0;
        for (int i = 0; i < 20; i++) begin
            do_read(8'(i), 1'b1, t);
        end
        check("R3 zero threshold silent", 32'(log_n), 32'd0);

        // R1 long LFSR run at half probability
        set_thr(16'h8000);
        cur_corr = 8'h09;
        for (int i = 0; i < 30; i++) begin
            log_n = 0;
            do_read(8'(8'h80 + i), 1'b1, t);
            wait_idle();
            check_log(t, 8'(8'h80 + i));
        end

        // R6 only reset clears the record
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R6 err cleared by reset", 32'(err_flag), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule